// File: doc/BRIEF.md
# I2C Bus Condition Generator

This block drives the data and clock lines of a simple I2C master. Each line has its own source selector. A line can follow the serial shifter, follow a small condition sequencer, be forced low, or be released. Software talks to the block through one byte-wide control register. Through that register it asks for a start, repeated-start or stop condition. It then watches a sticky completion flag and clears the flag before it issues the next request.

Both lines are open-drain. An asserted output enable pulls the line low, and a deasserted one releases it. A request is checked against the sampled pin levels when it is written. The sequencer then walks through a fixed list of line steps, with a programmable hold count between steps. When the last hold expires, the request bit clears and the completion flag is set. Writing 0 over an active request bit cancels that condition.

Top module: `i2c_cond_gen`

## Requirements
- R1: After reset every control register bit is 0, so `rd_data` reads 0x00 and `done_flag` is 0. `rd_data` shows the register as follows: start request in bit0, restart request in bit1, stop request in bit2, completion flag in bit3, data-line select in bits[5:4], clock-line select in bits[7:6].
- R2: Each line's 2-bit select works like this. 00 makes the output enable the inverse of the shifter bit (`ser_data` for the data line, `ser_clk` for the clock line). 01 hands the line to the sequencer. 10 asserts the enable. 11 deasserts it. A write always updates both select fields.
- R3: A write starts a condition only if all of the following hold: both written select fields are 01, the flag is 0, no condition is in progress, and exactly one of bits[2:0] is 1. In every other case the request bits stay 0.
- R4: A start is accepted only while `sda_in` and `scl_in` are both high. Let H be `hold_cnt` and let E be the accepting edge. At edge E the sequencer pulls data low with clock released. At E+(H+1) it pulls clock low. At E+2(H+1) the start completes.
- R5: A restart is accepted only while `scl_in` is low. It takes four steps, at E, E+(H+1), E+2(H+1) and E+3(H+1): data released with clock low, then both released, then data low with clock released, then both low. It completes at E+4(H+1).
- R6: A stop is accepted only while `scl_in` is low. It takes three steps, at E, E+(H+1) and E+2(H+1): both low, then data low with clock released, then both released. It completes at E+3(H+1).
- R7: On the completing edge the request bit clears and the flag (bit3) becomes 1. While a condition is in progress the flag is 0.
- R8: Writing 0 to bit3 clears the flag. Writing 1 to bit3 leaves the flag unchanged. Without a clearing write, the flag stays 1.
- R9: A write that puts 0 in the active request bit cancels the condition. The request bit clears, the flag stays 0, and the sequencer keeps its current line levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| hold_cnt | input | HOLD_W | Hold count H between sequencer steps |
| sda_in | input | 1 | Sampled data line level |
| scl_in | input | 1 | Sampled clock line level |
| ser_data | input | 1 | Serial data bit from the shifter |
| ser_clk | input | 1 | Serial clock from the shifter |
| sda_oe | output | 1 | Data line pull-low enable |
| scl_oe | output | 1 | Clock line pull-low enable |
| done_flag | output | 1 | Completion flag |

## Verification
The assertions check the following rules on every cycle:
- At most one request bit is ever active.
- A newly accepted request saw legal pin levels and a clear flag.
- The flag rises only as a request retires.
- The flag never drops without a clearing write.
- A cancel leaves no request and no flag.

Some behaviour only the bench scenarios can show:
- the exact step order and spacing on both lines for each condition type and for different hold counts;
- the read-back of rejected writes;
- the levels held after a cancel.

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic [HOLD_W-1:0] hold_cnt,
  input  logic              sda_in,
  input  logic              scl_in,
  input  logic              ser_data,
  input  logic              ser_clk,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              done_flag
);

  localparam logic [1:0] SEL_SER = 2'b00;
  localparam logic [1:0] SEL_GEN = 2'b01;
  localparam logic [1:0] SEL_LOW = 2'b10;

  logic [2:0]        req;
  logic              flag;
  logic [1:0]        sda_sel, scl_sel;
  logic [1:0]        step;
  logic [HOLD_W-1:0] cnt;
  logic              g_sda_low, g_scl_low;

  logic [2:0] w_req;
  logic       busy, one_req, legal, accept, cancel, last_step, hold_done;

  function automatic logic [1:0] step_lvl(input logic [2:0] r, input logic [1:0] s);
    logic [1:0] v;
    v = 2'b00;
    if (r[0]) v = (s == 2'd0) ? 2'b10 : 2'b11;
    else if (r[1]) begin
      case (s)
        2'd0:    v = 2'b01;
        2'd1:    v = 2'b00;
        2'd2:    v = 2'b10;
        default: v = 2'b11;
      endcase
    end else if (r[2]) begin
      case (s)
        2'd0:    v = 2'b11;
        2'd1:    v = 2'b10;
        default: v = 2'b00;
      endcase
    end
    return v;
  endfunction

  function automatic logic line_oe(input logic [1:0] sel, input logic ser, input logic gen);
    case (sel)
      SEL_SER: return ~ser;
      SEL_GEN: return gen;
      SEL_LOW: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  assign w_req     = wr_data[2:0];
  assign busy      = |req;
  assign one_req   = (w_req == 3'b001) || (w_req == 3'b010) || (w_req == 3'b100);
  assign legal     = w_req[0] ? (sda_in && scl_in) : !scl_in;
  assign accept    = wr_en && !busy && !flag && one_req && legal &&
                     (wr_data[5:4] == SEL_GEN) && (wr_data[7:6] == SEL_GEN);
  assign cancel    = wr_en && busy && ((req & ~w_req) != 3'b000);
  assign hold_done = (cnt == '0);
  assign last_step = (req[0] && step == 2'd1) || (req[1] && step == 2'd3) ||
                     (req[2] && step == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req       <= '0;
      flag      <= 1'b0;
      sda_sel   <= SEL_SER;
      scl_sel   <= SEL_SER;
      step      <= '0;
      cnt       <= '0;
      g_sda_low <= 1'b0;
      g_scl_low <= 1'b0;
    end else begin
      if (wr_en) begin
        sda_sel <= wr_data[5:4];
        scl_sel <= wr_data[7:6];
        if (!wr_data[3]) flag <= 1'b0;
      end
      if (accept) begin
        req                    <= w_req;
        step                   <= 2'd0;
        cnt                    <= hold_cnt;
        {g_sda_low, g_scl_low} <= step_lvl(w_req, 2'd0);
      end else if (cancel) begin
        req <= '0;
      end else if (busy && hold_done) begin
        if (last_step) begin
          req  <= '0;
          flag <= 1'b1;
        end else begin
          step                   <= step + 2'd1;
          cnt                    <= hold_cnt;
          {g_sda_low, g_scl_low} <= step_lvl(req, step + 2'd1);
        end
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign sda_oe    = line_oe(sda_sel, ser_data, g_sda_low);
  assign scl_oe    = line_oe(scl_sel, ser_clk, g_scl_low);
  assign done_flag = flag;
  assign rd_data   = {scl_sel, sda_sel, flag, req};

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req)); // R3
  AST_NEW_REQ_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(flag)); // R3
  AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req[0]) |-> $past(sda_in && scl_in)); // R4
  AST_RESTART_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req[1]) |-> $past(!scl_in)); // R5
  AST_STOP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req[2]) |-> $past(!scl_in)); // R6
  AST_FLAG_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(req) != 3'b000 && req == 3'b000)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && !wr_data[3])) |=> flag); // R8
  AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && (req & ~wr_data[2:0]) != 3'b000) |=> (req == 3'b000 && !flag)); // R9

endmodule

// File: tb/i2c_cond_gen_test.sv
module i2c_cond_gen_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [7:0] hold_cnt = 8'd2;
  logic       ser_data = 1'b1, ser_clk = 1'b1;
  logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic       sda_oe, scl_oe, done_flag, sda_in, scl_in;

  assign sda_in = !sda_oe && !ext_sda_low;
  assign scl_in = !scl_oe && !ext_scl_low;

  i2c_cond_gen #(.HOLD_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .hold_cnt(hold_cnt), .sda_in(sda_in), .scl_in(scl_in), .ser_data(ser_data),
    .ser_clk(ser_clk), .sda_oe(sda_oe), .scl_oe(scl_oe), .done_flag(done_flag)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit finished = 0;

  logic [2:0] m_req = 0;
  logic       m_flag = 0;
  logic [1:0] m_sda_sel = 0, m_scl_sel = 0;
  logic       m_gsda = 0, m_gscl = 0;
  int         q[$];
  logic       p_sda = 1, p_scl = 1;
  logic [2:0] w;
  logic       m_busy, m_acc, m_can;
  int         e;

  task automatic build_q(input logic [2:0] r);
    int lv[$];
    if (r[0]) lv = '{2, 3};
    else if (r[1]) lv = '{1, 0, 2, 3};
    else lv = '{3, 2, 0};
    q.delete();
    foreach (lv[i]) for (int k = 0; k <= int'(hold_cnt); k++) q.push_back(lv[i]);
    q.push_back(4);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_flag = 0; m_sda_sel = 0; m_scl_sel = 0; m_gsda = 0; m_gscl = 0;
      q.delete();
    end else begin
      w      = wr_data[2:0];
      m_busy = (m_req != 0);
      m_acc  = wr_en && !m_busy && !m_flag && (w == 1 || w == 2 || w == 4) &&
               wr_data[7:4] == 4'h5 && (w == 1 ? (p_sda && p_scl) : !p_scl);
      m_can  = wr_en && m_busy && ((m_req & ~w) != 0);
      if (wr_en) begin
        m_sda_sel = wr_data[5:4];
        m_scl_sel = wr_data[7:6];
        if (!wr_data[3]) m_flag = 0;
      end
      if (m_acc) begin
        m_req = w;
        build_q(w);
        e = q.pop_front();
        {m_gsda, m_gscl} = 2'(e);
      end else if (m_can) begin
        m_req = 0;
        q.delete();
      end else if (m_busy) begin
        e = q.pop_front();
        if (e == 4) begin m_req = 0; m_flag = 1; end
        else {m_gsda, m_gscl} = 2'(e);
      end
    end
  end

  function automatic logic exp_oe(input logic [1:0] sel, input logic ser, input logic g);
    if (sel == 0) return !ser;
    if (sel == 1) return g;
    return sel == 2;
  endfunction

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (sda_oe !== exp_oe(m_sda_sel, ser_data, m_gsda) ||
          scl_oe !== exp_oe(m_scl_sel, ser_clk, m_gscl) ||
          rd_data !== {m_scl_sel, m_sda_sel, m_flag, m_req} || done_flag !== m_flag) begin
        fails++;
        $display("FAIL %s cycle compare: actual oe=%b%b rd=%h flag=%b expected oe=%b%b rd=%h flag=%b",
                 tag, sda_oe, scl_oe, rd_data, done_flag,
                 exp_oe(m_sda_sel, ser_data, m_gsda), exp_oe(m_scl_sel, ser_clk, m_gscl),
                 {m_scl_sel, m_sda_sel, m_flag, m_req}, m_flag);
      end
    end
    p_sda = sda_in;
    p_scl = scl_in;
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); #1;
    wr_en = 1; wr_data = b;
    @(negedge clk); #1;
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic done_up;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done_up();
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(1);
    tag = "R1";
    chk("R1 reset rd_data", rd_data, 8'h00);
    chk("R1 reset flag", done_flag, 0);

    tag = "R2";
    ser_data = 0; ser_clk = 0; wait_n(1);
    chk("R2 shifter select low", {sda_oe, scl_oe}, 2'b11);
    ser_data = 1; wait_n(1);
    chk("R2 shifter select mixed", {sda_oe, scl_oe}, 2'b01);
    ser_clk = 1;
    wr(8'hA0);
    chk("R2 forced low", {sda_oe, scl_oe}, 2'b11);
    wr(8'hF0);
    chk("R2 released", {sda_oe, scl_oe}, 2'b00);
    wr(8'hB0);
    chk("R2 scl low sda hiz", {sda_oe, scl_oe}, 2'b01);
    chk("R2 read back", rd_data, 8'hB0);

    tag = "R3";
    wr(8'h61);
    chk("R3 select not 01 ignored", rd_data, 8'h60);
    wr(8'h50);
    wr(8'h53);
    chk("R3 multiple requests ignored", rd_data, 8'h50);

    tag = "R6";
    wr(8'h54);
    chk("R6 stop with clock high ignored", rd_data, 8'h50);

    tag = "R4";
    ext_scl_low = 1;
    wr(8'h51);
    chk("R4 start with clock low ignored", rd_data, 8'h50);
    ext_scl_low = 0;
    hold_cnt = 2;
    wr(8'h51);
    chk("R4 start step0", {sda_oe, scl_oe}, 2'b10);
    chk("R7 flag low in progress", done_flag, 0);
    wait_n(3);
    chk("R4 start step1", {sda_oe, scl_oe}, 2'b11);
    wait_n(3);
    tag = "R7";
    chk("R7 start done", rd_data, 8'h58);

    tag = "R8";
    wr(8'h5C);
    chk("R8 write one keeps flag and R3 request blocked", rd_data, 8'h58);
    wait_n(4);
    chk("R8 flag sticky", done_flag, 1);
    wr(8'h50);
    chk("R8 flag cleared", rd_data, 8'h50);

    tag = "R5";
    wr(8'h52);
    chk("R5 restart step0", {sda_oe, scl_oe}, 2'b01);
    wait_n(3);
    chk("R5 restart step1", {sda_oe, scl_oe}, 2'b00);
    wait_n(3);
    chk("R5 restart step2", {sda_oe, scl_oe}, 2'b10);
    wait_n(3);
    chk("R5 restart step3", {sda_oe, scl_oe}, 2'b11);
    wait_n(3);
    chk("R5 R7 restart done", rd_data, 8'h58);
    wr(8'h50);

    tag = "R6";
    hold_cnt = 0;
    wr(8'h54);
    chk("R6 stop step0", {sda_oe, scl_oe}, 2'b11);
    wait_n(1);
    chk("R6 stop step1", {sda_oe, scl_oe}, 2'b10);
    wait_n(1);
    chk("R6 stop step2", {sda_oe, scl_oe}, 2'b00);
    wait_n(1);
    chk("R6 R7 stop done", rd_data, 8'h58);
    wr(8'h50);

    tag = "R9";
    hold_cnt = 5;
    wr(8'h51);
    wait_n(2);
    wr(8'h50);
    chk("R9 cancel clears request", rd_data, 8'h50);
    wait_n(10);
    chk("R9 flag stays low", done_flag, 0);
    chk("R9 levels held", {sda_oe, scl_oe}, 2'b10);
    wr(8'hF0);
    chk("R2 release after cancel", {sda_oe, scl_oe}, 2'b00);
    wait_n(2);
    done_up();
  end
endmodule